// File: doc/BRIEF.md
# Pooled-FIFO HDLC Frame Transmitter

This block turns bytes written by a CPU into a bit-oriented HDLC frame on a serial line. The CPU deposits bytes through a single-cycle write strobe into a 64-byte transmit FIFO. The FIFO is managed as two 32-byte pools. A transmit command starts a frame. If the command carries an end-of-message mark, the block sends the stored bytes and then closes the frame. If it does not, the block sends what it has and raises a sticky pool-ready interrupt as soon as a pool is free again, so that the CPU can refill it and issue a further command.

On the line the block sends continuous 0x7E flags while idle. A frame is an opening flag, the payload sent least significant bit first, a complemented CRC-16-CCITT check sequence and a closing flag. A 0 bit is inserted after every five consecutive 1 bits of payload and check sequence. If the FIFO runs dry before the end-of-message mark arrives, the frame is killed with eight 1 bits and a sticky underrun interrupt is raised. A transmitter reset command empties the FIFO and aborts any frame in progress. The active-low clear-to-send input freezes the line whenever it is high. Each line bit is presented on `txBit` together with a one-cycle `txStrobe`. The load cycle between characters emits no bit.

Top module: `hdlcPoolTx`

## Requirements
- R1: During and after reset `txStrobe` is low until the first bit, `poolFree` is 1 and both interrupts are 0. With no command pending the line carries back-to-back 0x7E flags and no frame.
- R2: A frame is sent as an opening flag, then the payload bytes in write order, each least significant bit first, then the two-byte check sequence, then a closing flag.
- R3: After five consecutive 1 bits inside the payload or check sequence, a 0 bit is inserted. Flags and abort sequences are sent without insertion.
- R4: The check sequence is CRC-16-CCITT in reflected form (feedback constant 0x8408) over the payload. It is preset to 0xFFFF, complemented, and sent low byte first.
- R5: The FIFO holds 64 bytes. A write strobe when it is full is ignored. `poolFree` is 1 exactly while 32 or fewer bytes are stored.
- R6: After a transmit command without the end mark, `irqPoolReady` is set once 32 or fewer bytes remain stored. It is not set while more than 32 bytes remain.
- R7: If the FIFO is empty when the next payload byte is needed and no end mark has been given, the block sends eight consecutive 1 bits instead of a check sequence, sets `irqUnderrun` and returns to idle flags. No frame is delivered.
- R8: `cmdReset` empties the FIFO and, if a frame is in progress, ends it with an abort sequence. It sets `irqPoolReady` and does not set `irqUnderrun`.
- R9: While `ctsN` is 1 no bit is emitted and no frame starts. Stored data and a pending command wait and are sent intact once `ctsN` returns to 0.
- R10: Both interrupts stay set until a cycle with `irqClr` high clears them. A set condition in the same cycle as `irqClr` wins.
- R11: Further transmit commands issued while a frame is being sent append the newly written bytes to the same frame. A command with the end mark makes that frame close normally.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| wrEn | input | 1 | One-cycle strobe writing `wrData` into the FIFO |
| wrData | input | 8 | Byte to store |
| cmdXmit | input | 1 | Transmit command strobe |
| cmdEom | input | 1 | End-of-message mark, qualified by `cmdXmit` |
| cmdReset | input | 1 | Transmitter reset command strobe |
| irqClr | input | 1 | Clears both sticky interrupts |
| ctsN | input | 1 | Clear to send, active low |
| txBit | output | 1 | Serial line bit, valid with `txStrobe` |
| txStrobe | output | 1 | High for one cycle per emitted line bit |
| poolFree | output | 1 | A 32-byte pool is free for writing |
| irqPoolReady | output | 1 | Sticky pool-ready interrupt |
| irqUnderrun | output | 1 | Sticky underrun interrupt |

## Verification
Two functions can fall in the same cycle. A CPU write can coincide with the serializer popping a byte, and an interrupt set can coincide with `irqClr`. The first is provoked by writing the second and third blocks of a long frame while it is already on the line. It is judged by decoding the line with an independent receiver model and requiring every byte and the check sequence to match. The second is provoked by driving `irqClr` and `cmdReset` in the same cycle, and it is judged by `irqPoolReady` still reading 1 afterwards.

// File: rtl/hdlcTxPkg.sv
package hdlcTxPkg;
  localparam logic [7:0]  FLAG_BYTE  = 8'h7E;
  localparam logic [7:0]  ABORT_BYTE = 8'hFF;
  localparam logic [15:0] CRC_POLY_R = 16'h8408;
  localparam logic [15:0] CRC_PRESET = 16'hFFFF;

  // strobes from control to datapath
  typedef struct packed {
    logic ldFlag;
    logic ldAbort;
    logic ldData;
    logic ldCrcLo;
    logic ldCrcHi;
    logic crcInit;
    logic flush;
  } txCtlT;

  typedef enum logic [2:0] {
    ST_IDLE, ST_DATA, ST_CRCH, ST_CLOSE, ST_ABRT
  } txStateT;
endpackage

// File: rtl/hdlcTxDatapath.sv
module hdlcTxDatapath
  import hdlcTxPkg::*;
#(
  parameter int DEPTH = 64,
  parameter int CW    = $clog2(DEPTH + 1)
)(
  input  logic          clk,
  input  logic          rstN,
  input  logic          wrEn,
  input  logic [7:0]    wrData,
  input  logic          adv,
  input  txCtlT         ctl,
  output logic          shEmpty,
  output logic          fifoEmpty,
  output logic [CW-1:0] fifoCount,
  output logic          txBit,
  output logic          txStrobe
);
  localparam int AW = $clog2(DEPTH);

  logic [7:0]    mem [DEPTH];
  logic [AW-1:0] rdPtr, wrPtr;
  logic [CW-1:0] count;
  logic          wrOk, pop;

  assign wrOk      = wrEn && (count < CW'(DEPTH));
  assign pop       = ctl.ldData && (count != '0);
  assign fifoCount = count;
  assign fifoEmpty = (count == '0);

  always_ff @(posedge clk) begin
    if (wrOk) mem[wrPtr] <= wrData;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      rdPtr <= '0;
      wrPtr <= '0;
      count <= '0;
    end else if (ctl.flush) begin
      rdPtr <= '0;
      wrPtr <= '0;
      count <= '0;
    end else begin
      if (wrOk) wrPtr <= wrPtr + 1'b1;
      if (pop)  rdPtr <= rdPtr + 1'b1;
      count <= count + CW'(wrOk) - CW'(pop);
    end
  end

  // serializer with zero insertion and CRC
  logic [7:0]  sh;
  logic [3:0]  bitCnt;
  logic [2:0]  ones;
  logic [15:0] crc;
  logic        stuffOn, crcOn, pendZero;

  function automatic logic [15:0] crcStep(input logic [15:0] c, input logic b);
    logic fb;
    fb = c[0] ^ b;
    return fb ? ((c >> 1) ^ CRC_POLY_R) : (c >> 1);
  endfunction

  assign shEmpty = (bitCnt == 4'd0) && !pendZero;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      sh <= '0; bitCnt <= '0; ones <= '0; crc <= CRC_PRESET;
      stuffOn <= 1'b0; crcOn <= 1'b0; pendZero <= 1'b0;
      txBit <= 1'b1; txStrobe <= 1'b0;
    end else begin
      txStrobe <= 1'b0;
      if (ctl.flush) begin
        bitCnt <= '0; pendZero <= 1'b0; ones <= '0;
      end else if (ctl.ldFlag || ctl.ldAbort) begin
        sh <= ctl.ldAbort ? ABORT_BYTE : FLAG_BYTE;
        bitCnt <= 4'd8; stuffOn <= 1'b0; crcOn <= 1'b0; ones <= '0;
        if (ctl.crcInit) crc <= CRC_PRESET;
      end else if (ctl.ldData) begin
        sh <= mem[rdPtr]; bitCnt <= 4'd8; stuffOn <= 1'b1; crcOn <= 1'b1;
      end else if (ctl.ldCrcLo || ctl.ldCrcHi) begin
        sh <= ctl.ldCrcLo ? ~crc[7:0] : ~crc[15:8];
        bitCnt <= 4'd8; stuffOn <= 1'b1; crcOn <= 1'b0;
      end else if (adv && pendZero) begin
        txBit <= 1'b0; txStrobe <= 1'b1; pendZero <= 1'b0; ones <= '0;
      end else if (adv && bitCnt != 4'd0) begin
        txBit <= sh[0]; txStrobe <= 1'b1;
        sh <= sh >> 1; bitCnt <= bitCnt - 4'd1;
        if (stuffOn) begin
          if (sh[0]) begin
            ones <= ones + 3'd1;
            if (ones == 3'd4) pendZero <= 1'b1;
          end else begin
            ones <= '0;
          end
        end
        if (crcOn) crc <= crcStep(crc, sh[0]);
      end
    end
  end

  a_r3_stuff_zero: assert property (@(posedge clk) disable iff (!rstN)
    (adv && pendZero && !ctl.flush) |=> (txStrobe && !txBit));
  a_r9_hold_line: assert property (@(posedge clk) disable iff (!rstN)
    !adv |=> !txStrobe);
  a_r5_full_ignore: assert property (@(posedge clk) disable iff (!rstN)
    (wrEn && count == CW'(DEPTH) && !pop && !ctl.flush) |=> (count == CW'(DEPTH)));
  a_r8_flush_empty: assert property (@(posedge clk) disable iff (!rstN)
    ctl.flush |=> (count == '0 && shEmpty));
endmodule

// File: rtl/hdlcTxCtrl.sv
module hdlcTxCtrl
  import hdlcTxPkg::*;
#(
  parameter int POOL = 32,
  parameter int CW   = 7
)(
  input  logic          clk,
  input  logic          rstN,
  input  logic          cmdXmit,
  input  logic          cmdEom,
  input  logic          cmdReset,
  input  logic          irqClr,
  input  logic          ctsN,
  input  logic          shEmpty,
  input  logic          fifoEmpty,
  input  logic [CW-1:0] fifoCount,
  output logic          adv,
  output txCtlT         ctl,
  output logic          irqPoolReady,
  output logic          irqUnderrun
);
  txStateT state, nxtState;
  logic startPend, endSeen, needBlk;
  logic setUnder, setPool, poolLow;

  assign adv     = !ctsN;
  assign poolLow = (fifoCount <= CW'(POOL));
  assign setPool = cmdReset || (needBlk && poolLow);

  always_comb begin
    ctl      = '0;
    nxtState = state;
    setUnder = 1'b0;
    if (cmdReset) begin
      ctl.flush = 1'b1;
      nxtState  = (state == ST_IDLE) ? ST_IDLE : ST_ABRT;
    end else if (adv && shEmpty) begin
      case (state)
        ST_IDLE: begin
          ctl.ldFlag = 1'b1;
          if (startPend) begin
            ctl.crcInit = 1'b1;
            nxtState    = ST_DATA;
          end
        end
        ST_DATA: begin
          if (!fifoEmpty) begin
            ctl.ldData = 1'b1;
          end else if (endSeen) begin
            ctl.ldCrcLo = 1'b1;
            nxtState    = ST_CRCH;
          end else begin
            ctl.ldAbort = 1'b1;
            setUnder    = 1'b1;
            nxtState    = ST_IDLE;
          end
        end
        ST_CRCH: begin
          ctl.ldCrcHi = 1'b1;
          nxtState    = ST_CLOSE;
        end
        ST_CLOSE: begin
          ctl.ldFlag = 1'b1;
          nxtState   = ST_IDLE;
        end
        default: begin
          ctl.ldAbort = 1'b1;
          nxtState    = ST_IDLE;
        end
      endcase
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state <= ST_IDLE;
      startPend <= 1'b0; endSeen <= 1'b0; needBlk <= 1'b0;
      irqPoolReady <= 1'b0; irqUnderrun <= 1'b0;
    end else begin
      state <= nxtState;
      if (cmdReset) begin
        startPend <= 1'b0; endSeen <= 1'b0; needBlk <= 1'b0;
      end else begin
        if (ctl.crcInit) startPend <= 1'b0;
        if (cmdXmit) begin
          if (startPend || state == ST_DATA) begin
            if (cmdEom) endSeen <= 1'b1;
          end else begin
            startPend <= 1'b1;
            endSeen   <= cmdEom;
          end
          needBlk <= !cmdEom;
        end else if (needBlk && poolLow) begin
          needBlk <= 1'b0;
        end
      end
      if (setPool)     irqPoolReady <= 1'b1;
      else if (irqClr) irqPoolReady <= 1'b0;
      if (setUnder)    irqUnderrun <= 1'b1;
      else if (irqClr) irqUnderrun <= 1'b0;
    end
  end

  a_r7_underrun: assert property (@(posedge clk) disable iff (!rstN)
    (state == ST_DATA && adv && shEmpty && fifoEmpty && !endSeen && !cmdReset)
      |=> irqUnderrun);
  a_r6_pool_ready: assert property (@(posedge clk) disable iff (!rstN)
    (needBlk && poolLow) |=> irqPoolReady);
  a_r10_set_wins: assert property (@(posedge clk) disable iff (!rstN)
    (cmdReset && irqClr) |=> irqPoolReady);
  a_r8_no_underrun: assert property (@(posedge clk) disable iff (!rstN)
    (cmdReset && !irqUnderrun) |=> !irqUnderrun);
endmodule

// File: rtl/hdlcPoolTx.sv
module hdlcPoolTx
  import hdlcTxPkg::*;
#(
  parameter int POOL  = 32,
  parameter int DEPTH = 2 * POOL
)(
  input  logic       clk,
  input  logic       rstN,
  input  logic       wrEn,
  input  logic [7:0] wrData,
  input  logic       cmdXmit,
  input  logic       cmdEom,
  input  logic       cmdReset,
  input  logic       irqClr,
  input  logic       ctsN,
  output logic       txBit,
  output logic       txStrobe,
  output logic       poolFree,
  output logic       irqPoolReady,
  output logic       irqUnderrun
);
  localparam int CW = $clog2(DEPTH + 1);

  txCtlT         ctl;
  logic          adv, shEmpty, fifoEmpty;
  logic [CW-1:0] fifoCount;

  assign poolFree = (fifoCount <= CW'(POOL));

  hdlcTxCtrl #(.POOL(POOL), .CW(CW)) u_ctrl (
    .clk(clk), .rstN(rstN), .cmdXmit(cmdXmit), .cmdEom(cmdEom),
    .cmdReset(cmdReset), .irqClr(irqClr), .ctsN(ctsN),
    .shEmpty(shEmpty), .fifoEmpty(fifoEmpty), .fifoCount(fifoCount),
    .adv(adv), .ctl(ctl), .irqPoolReady(irqPoolReady), .irqUnderrun(irqUnderrun)
  );

  hdlcTxDatapath #(.DEPTH(DEPTH), .CW(CW)) u_dp (
    .clk(clk), .rstN(rstN), .wrEn(wrEn), .wrData(wrData), .adv(adv), .ctl(ctl),
    .shEmpty(shEmpty), .fifoEmpty(fifoEmpty), .fifoCount(fifoCount),
    .txBit(txBit), .txStrobe(txStrobe)
  );
endmodule

// File: tb/hdlcPoolTx_tb.sv
module hdlcPoolTx_tb;
  logic clk = 1'b0, rstN = 1'b0;
  logic wrEn = 1'b0, cmdXmit = 1'b0, cmdEom = 1'b0, cmdReset = 1'b0;
  logic irqClr = 1'b0, ctsN = 1'b0;
  logic [7:0] wrData = '0;
  logic txBit, txStrobe, poolFree, irqPoolReady, irqUnderrun;

  always #4 clk = ~clk;

  hdlcPoolTx u_dut (
    .clk(clk), .rstN(rstN), .wrEn(wrEn), .wrData(wrData), .cmdXmit(cmdXmit),
    .cmdEom(cmdEom), .cmdReset(cmdReset), .irqClr(irqClr), .ctsN(ctsN),
    .txBit(txBit), .txStrobe(txStrobe), .poolFree(poolFree),
    .irqPoolReady(irqPoolReady), .irqUnderrun(irqUnderrun)
  );

  int tests = 0, fails = 0;

  // len, base, step, expected received bytes (payload + FCS)
  localparam int VEC [6][4] = '{
    '{1, 90, 0, 3}, '{3, 0, 1, 5}, '{16, 255, 0, 18},
    '{32, 126, 0, 34}, '{20, 63, 17, 22}, '{5, 248, 7, 7}
  };

  // independent line receiver
  int ones = 0, nb = 0, framesGot = 0, abortsGot = 0, flagsGot = 0;
  int stuffSeen = 0, badFrames = 0, strobes = 0, rxLen = 0;
  bit hunting = 1'b1;
  bit bits [0:1023];
  logic [7:0] rxBytes [0:127];

  task automatic frameDone(input int n);
    if (n % 8 != 0 || n < 24 || n / 8 > 128) begin
      badFrames++;
    end else begin
      rxLen = n / 8;
      for (int i = 0; i < rxLen; i++)
        for (int k = 0; k < 8; k++) rxBytes[i][k] = bits[i*8+k];
      framesGot++;
    end
  endtask

  task automatic rxBit(input bit b);
    if (ones == 5 && !b) begin
      ones = 0; stuffSeen++;
    end else if (b) begin
      ones++;
      if (ones == 7) begin abortsGot++; hunting = 1'b1; nb = 0; end
      if (ones < 7 && !hunting && nb < 1024) begin bits[nb] = 1'b1; nb++; end
    end else begin
      if (ones == 6) begin
        flagsGot++;
        if (!hunting && nb > 7) frameDone(nb - 7);
        nb = 0; hunting = 1'b0;
      end else if (!hunting && nb < 1024) begin
        bits[nb] = 1'b0; nb++;
      end
      ones = 0;
    end
  endtask

  always @(negedge clk) if (rstN && txStrobe) begin strobes++; rxBit(txBit); end

  task automatic chk(input bit ok, input string req, input string what,
                     input int act, input int exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  task automatic tick(input int n); repeat (n) @(negedge clk); endtask
  task automatic wr(input logic [7:0] d); wrEn = 1'b1; wrData = d; tick(1); wrEn = 1'b0; endtask
  task automatic cmd(input bit eom);
    cmdXmit = 1'b1; cmdEom = eom; tick(1); cmdXmit = 1'b0; cmdEom = 1'b0;
  endtask
  task automatic clrIrq(); irqClr = 1'b1; tick(1); irqClr = 1'b0; endtask
  task automatic waitFrames(input int target);
    for (int c = 0; c < 4000 && framesGot < target; c++) tick(1);
    tick(2);
  endtask

  function automatic logic [7:0] pat(input int base, input int step, input int i);
    return 8'((base + step * i) & 255);
  endfunction

  function automatic logic [15:0] fcsOf(input int len, input int base, input int step);
    logic [15:0] c;
    logic [7:0] d;
    logic fb;
    c = 16'hFFFF;
    for (int i = 0; i < len; i++) begin
      d = pat(base, step, i);
      for (int k = 0; k < 8; k++) begin
        fb = c[0] ^ d[k];
        c = c >> 1;
        if (fb) c = c ^ 16'h8408;
      end
    end
    return ~c;
  endfunction

  function automatic int payloadErrs(input int len, input int base, input int step);
    int e;
    e = 0;
    for (int i = 0; i < len; i++) if (rxBytes[i] != pat(base, step, i)) e++;
    return e;
  endfunction

  task automatic judgeFrame(input string req, input int prevF, input int len,
                            input int base, input int step);
    logic [15:0] got;
    chk(framesGot == prevF + 1, req, "frame delivered", framesGot, prevF + 1);
    chk(rxLen == len + 2, req, "received length", rxLen, len + 2);
    chk(payloadErrs(len, base, step) == 0, req, "payload mismatches",
        payloadErrs(len, base, step), 0);
    got = {rxBytes[len+1], rxBytes[len]};
    chk(got == fcsOf(len, base, step), "R4", "check sequence", int'(got),
        int'(fcsOf(len, base, step)));
  endtask

  task automatic summary();
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    fails++;
    $display("FAIL R1 watchdog: actual timeout expected completion");
    summary();
  end

  initial begin
    int prevF, prevA, prevS, base;
    tick(3);
    chk(!txStrobe && poolFree && !irqPoolReady && !irqUnderrun, "R1",
        "reset outputs", {txStrobe, poolFree, irqPoolReady, irqUnderrun}, 4'b0100);
    rstN = 1'b1;
    tick(120);
    chk(flagsGot >= 8 && framesGot == 0 && badFrames == 0, "R1", "idle flags",
        flagsGot, 8);

    // vector table: single-command frames (R2, R3, R4)
    for (int v = 0; v < 6; v++) begin
      prevF = framesGot;
      prevS = stuffSeen;
      for (int i = 0; i < VEC[v][0]; i++) wr(pat(VEC[v][1], VEC[v][2], i));
      cmd(1'b1);
      waitFrames(prevF + 1);
      judgeFrame("R2", prevF, VEC[v][3] - 2, VEC[v][1], VEC[v][2]);
      if (VEC[v][1] == 255)
        chk(stuffSeen - prevS >= 25, "R3", "inserted zeros in all-ones payload",
            stuffSeen - prevS, 25);
    end
    chk(badFrames == 0, "R3", "malformed frames", badFrames, 0);

    // full FIFO and pool-free flag (R5)
    clrIrq();
    for (int i = 0; i < 32; i++) wr(pat(0, 1, i));
    chk(poolFree == 1'b1, "R5", "poolFree at 32 stored", poolFree, 1);
    wr(pat(0, 1, 32));
    chk(poolFree == 1'b0, "R5", "poolFree at 33 stored", poolFree, 0);
    for (int i = 33; i < 70; i++) wr(pat(0, 1, i));
    prevF = framesGot;
    cmd(1'b1);
    waitFrames(prevF + 1);
    judgeFrame("R5", prevF, 64, 0, 1);

    // multi-block frame with pool-ready handshake (R6, R10, R11)
    clrIrq();
    prevF = framesGot;
    base = 17;
    for (int i = 0; i < 32; i++) wr(pat(base, 3, i));
    cmd(1'b0);
    tick(3);
    chk(irqPoolReady == 1'b1, "R6", "pool ready after first block", irqPoolReady, 1);
    clrIrq();
    chk(irqPoolReady == 1'b0, "R10", "pool ready cleared", irqPoolReady, 0);
    for (int i = 32; i < 64; i++) wr(pat(base, 3, i));
    cmd(1'b0);
    tick(3);
    chk(irqPoolReady == 1'b0, "R6", "no pool ready above 32 stored", irqPoolReady, 0);
    chk(poolFree == 1'b0, "R5", "poolFree with second block", poolFree, 0);
    for (int c = 0; c < 3000 && !irqPoolReady; c++) tick(1);
    chk(irqPoolReady == 1'b1, "R6", "pool ready after drain", irqPoolReady, 1);
    for (int i = 64; i < 80; i++) wr(pat(base, 3, i));
    cmd(1'b1);
    waitFrames(prevF + 1);
    judgeFrame("R11", prevF, 80, base, 3);

    // underrun (R7, R10)
    clrIrq();
    prevF = framesGot;
    prevA = abortsGot;
    for (int i = 0; i < 4; i++) wr(pat(200, 1, i));
    cmd(1'b0);
    for (int c = 0; c < 500 && abortsGot == prevA; c++) tick(1);
    tick(2);
    chk(abortsGot == prevA + 1, "R7", "abort sequence seen", abortsGot, prevA + 1);
    chk(irqUnderrun == 1'b1, "R7", "underrun interrupt", irqUnderrun, 1);
    tick(60);
    chk(framesGot == prevF, "R7", "no frame delivered", framesGot, prevF);
    chk(irqUnderrun == 1'b1, "R10", "underrun stays sticky", irqUnderrun, 1);
    clrIrq();
    chk(irqUnderrun == 1'b0, "R10", "underrun cleared", irqUnderrun, 0);

    // set wins over clear (R10)
    clrIrq();
    cmdReset = 1'b1; irqClr = 1'b1; tick(1); cmdReset = 1'b0; irqClr = 1'b0;
    chk(irqPoolReady == 1'b1, "R10", "set beats clear", irqPoolReady, 1);

    // reset command mid-frame (R8)
    clrIrq();
    prevF = framesGot;
    prevA = abortsGot;
    for (int i = 0; i < 30; i++) wr(pat(9, 5, i));
    cmd(1'b1);
    tick(100);
    cmdReset = 1'b1; tick(1); cmdReset = 1'b0;
    tick(150);
    chk(abortsGot == prevA + 1, "R8", "abort on reset", abortsGot, prevA + 1);
    chk(framesGot == prevF, "R8", "frame discarded", framesGot, prevF);
    chk(irqPoolReady && !irqUnderrun && poolFree, "R8", "flags after reset",
        {irqPoolReady, irqUnderrun, poolFree}, 3'b101);
    prevF = framesGot;
    wr(8'hA5); wr(8'h3C);
    cmd(1'b1);
    waitFrames(prevF + 1);
    judgeFrame("R8", prevF, 2, 165, -105);

    // clear to send (R9)
    ctsN = 1'b1;
    tick(2);
    prevS = strobes;
    prevF = framesGot;
    for (int i = 0; i < 3; i++) wr(pat(66, 9, i));
    cmd(1'b1);
    tick(60);
    chk(strobes == prevS, "R9", "no bits while ctsN high", strobes - prevS, 0);
    chk(framesGot == prevF, "R9", "no frame while ctsN high", framesGot, prevF);
    ctsN = 1'b0;
    waitFrames(prevF + 1);
    judgeFrame("R9", prevF, 3, 66, 9);

    summary();
  end
endmodule